// File: doc/BRIEF.md
# Vectored Interrupt Flag Controller

This block sits beside a small processor core and decides which of eight interrupt sources is served next. A parameter mask sets the kind of each source. Latched sources capture a one-cycle event into a pending flag. Level sources have no flag and request service only while their input is high. Each source has its own enable bit, and a single global enable gates every source. When the core signals that it is ready, the block picks the highest-priority source that is enabled and requesting. It registers that source's vector and raises a one-cycle acknowledge. It also clears the global enable and, for a latched source, the flag of the source it served.

Software uses a small write port. One register holds the individual enables. A write-one-to-clear port removes pending flags. A third register writes the global enable directly. A return-from-interrupt strobe sets the global enable again. The arbiter is a three-state machine. `ST_ARB` evaluates requests and moves to `ST_ACK` on a take, which needs ready, global enable and a request. `ST_ACK` drives the acknowledge and always moves to `ST_HOLD`. `ST_HOLD` returns to `ST_ARB` once `core_ready` falls, so no new request is evaluated until the core asserts ready again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: No interrupt is taken while the global enable is 0, whatever the individual enables hold.
- R2: The global enable resets to 0. A take clears it. Otherwise a write to address 2 loads it from `wr_data[0]`, and otherwise a `reti` strobe sets it to 1. Take has precedence over the write, and the write has precedence over `reti`.
- R3: When a latched source is served, its flag is cleared on the same edge that registers the vector.
- R4: A write to address 1 clears each flag whose `wr_data` bit is 1 and leaves flags whose bit is 0 unchanged. An event on the same cycle as a clear leaves the flag set.
- R5: An event on a latched source sets its flag even while its enable is 0. The flag then causes an interrupt once enabled, unless software cleared it first, in which case no interrupt follows.
- R6: A level source requests only in cycles where its input and its enable are both 1. An input that fell before the source was enabled causes no interrupt.
- R7: Among requesting sources, the lowest index wins.
- R8: `irq_vector` resets to `VEC_BASE` (the reset vector, 0 by default). Source i yields `VEC_BASE + (i+1)*VEC_STEP`, which is 2*(i+1) by default.
- R9: A take happens in `ST_ARB` at a clock edge where `core_ready` is 1. `irq_ack` is then high for exactly the next cycle. `irq_vector` changes only on a take. After the acknowledge, the block waits for `core_ready` to be 0 before it arbitrates again.
- R10: The write-port address encoding is: 0 loads the individual enables (bit i enables source i), 1 clears flags, 2 loads the global enable, and 3 has no effect.
- R11: `EDGE_MASK` bit i set to 1 makes source i latched. Set to 0, source i is a level source. `pend_o` shows the flags, and level-source bits always read 0. The default mask is 8'h0F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | N_SRC | Event pulses for latched sources; live conditions for level sources |
| core_ready | input | 1 | Core can accept an interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 enables, 1 flag clear, 2 global enable) |
| wr_data | input | N_SRC | Write data |
| irq_ack | output | 1 | One-cycle acknowledge of a taken interrupt |
| irq_vector | output | VEC_W | Registered vector of the served source |
| gie_o | output | 1 | Current global enable |
| pend_o | output | N_SRC | Pending flags of latched sources |

## Verification
The in-design assertions check several rules on every cycle:
- an acknowledge is never raised without the global enable having been set, and the enable is off during the acknowledge;
- the acknowledge lasts exactly one cycle, and the vector moves only on a take;
- each flag is set by an event, survives until cleared, and is removed by a hardware take or by a software write of one;
- a level source is only served while its input is present.

Only the bench scenarios can show the rest. These include lowest-index arbitration among mixed latched and level requests, and an event that fell before its enable was written producing nothing. They also cover a cleared flag never firing, the exact precedence between take, write and return strobe on the global enable, and the ready handshake across many random sequences.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_ARB  = 2'd0,
        ST_ACK  = 2'd1,
        ST_HOLD = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        WR_ENABLE  = 2'd0,
        WR_FLAGCLR = 2'd1,
        WR_GLOBAL  = 2'd2,
        WR_NONE    = 2'd3
    } wr_addr_e;

endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
    parameter int                N_SRC     = 8,
    parameter logic [N_SRC-1:0]  EDGE_MASK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] clr_mask,
    input  logic [N_SRC-1:0] take_oh,
    output logic [N_SRC-1:0] req,
    output logic [N_SRC-1:0] flags
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_latched
            logic flag_q;

            // An event wins over a clear on the same edge so it is never lost
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else if (evt[i])
                    flag_q <= 1'b1;
                else if (clr_mask[i] || take_oh[i])
                    flag_q <= 1'b0;
            end

            assign flags[i] = flag_q;
            assign req[i]   = flag_q & en[i];

            a_r3_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
                take_oh[i] && !evt[i] |=> !flag_q);
            a_r4_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
                clr_mask[i] && !evt[i] |=> !flag_q);
            a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> flag_q);
            a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
                flag_q && !clr_mask[i] && !take_oh[i] |=> flag_q);
        end else begin : g_level
            logic unused_lvl;
            assign unused_lvl = clr_mask[i] ^ take_oh[i];
            assign flags[i]   = 1'b0;
            assign req[i]     = evt[i] & en[i];

            a_r6_level_live: assert property (@(posedge clk) disable iff (!rst_n)
                take_oh[i] |-> evt[i] && en[i]);
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N_SRC    = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 0,
    parameter int VEC_STEP = 2
) (
    input  logic [N_SRC-1:0] req,
    output logic             any,
    output logic [N_SRC-1:0] pick_oh,
    output logic [VEC_W-1:0] vec
);

    // Scan from the top down so the lowest requesting index is left standing
    always_comb begin
        any     = 1'b0;
        pick_oh = '0;
        vec     = VEC_W'(VEC_BASE);
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                any        = 1'b1;
                pick_oh    = '0;
                pick_oh[i] = 1'b1;
                vec        = VEC_W'(VEC_BASE + (i + 1) * VEC_STEP);
            end
        end
    end

    always_comb begin
        a_r7_lowest_wins: assert (!any || ((req & (pick_oh - 1'b1)) == '0));
        a_r7_single_pick: assert ($onehot0(pick_oh));
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int               N_SRC     = 8,
    parameter logic [N_SRC-1:0] EDGE_MASK = 8'h0F,
    parameter int               VEC_W     = 8,
    parameter int               VEC_BASE  = 0,
    parameter int               VEC_STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic             core_ready,
    input  logic             reti,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [N_SRC-1:0] wr_data,
    output logic             irq_ack,
    output logic [VEC_W-1:0] irq_vector,
    output logic             gie_o,
    output logic [N_SRC-1:0] pend_o
);

    localparam logic [VEC_W-1:0] RESET_VEC = VEC_W'(VEC_BASE);

    arb_state_e       state_q, state_d;
    wr_addr_e         wsel;
    logic             gie_q;
    logic [N_SRC-1:0] en_q;
    logic [VEC_W-1:0] vec_q;
    logic [N_SRC-1:0] req, pick_oh, take_oh, clr_mask, flags;
    logic [VEC_W-1:0] pick_vec;
    logic             any_req, take;

    assign wsel     = wr_addr_e'(wr_addr);
    assign clr_mask = (wr_en && wsel == WR_FLAGCLR) ? wr_data : '0;

    irqc_src_bank #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (src_evt),
        .en       (en_q),
        .clr_mask (clr_mask),
        .take_oh  (take_oh),
        .req      (req),
        .flags    (flags)
    );

    irqc_prio #(.N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_prio (
        .req     (req),
        .any     (any_req),
        .pick_oh (pick_oh),
        .vec     (pick_vec)
    );

    assign take    = (state_q == ST_ARB) && core_ready && gie_q && any_req;
    assign take_oh = take ? pick_oh : '0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_ARB;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARB:  if (take)        state_d = ST_ACK;
            ST_ACK:                   state_d = ST_HOLD;
            ST_HOLD: if (!core_ready) state_d = ST_ARB;
            default:                  state_d = ST_ARB;
        endcase
    end

    // Outputs
    always_comb begin
        irq_ack    = (state_q == ST_ACK);
        irq_vector = vec_q;
        gie_o      = gie_q;
        pend_o     = flags;
    end

    // Control registers: take beats a global write, which beats the return strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            en_q  <= '0;
            vec_q <= RESET_VEC;
        end else begin
            if (take)
                gie_q <= 1'b0;
            else if (wr_en && wsel == WR_GLOBAL)
                gie_q <= wr_data[0];
            else if (reti)
                gie_q <= 1'b1;
            if (wr_en && wsel == WR_ENABLE)
                en_q <= wr_data;
            if (take)
                vec_q <= pick_vec;
        end
    end

    a_r1_ack_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(gie_q));
    a_r2_gie_off_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !gie_q);
    a_r2_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
        reti && !take && !(wr_en && wsel == WR_GLOBAL) |=> gie_q);
    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);
    a_r9_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(irq_vector));
    a_r9_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HOLD && core_ready |=> !irq_ack);

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

    localparam int         N        = 8;
    localparam logic [7:0] EDGE     = 8'h0F;
    localparam int         VBASE    = 0;
    localparam int         VSTEP    = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_evt = '0;
    logic       core_ready = 1'b0;
    logic       reti = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq_ack;
    logic [7:0] irq_vector;
    logic       gie_o;
    logic [7:0] pend_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [7:0] lvl_hold = '0;
    logic       mdl_on = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl #(.N_SRC(N), .EDGE_MASK(EDGE), .VEC_W(8), .VEC_BASE(VBASE), .VEC_STEP(VSTEP)) u0 (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .core_ready(core_ready), .reti(reti),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_ack(irq_ack),
        .irq_vector(irq_vector), .gie_o(gie_o), .pend_o(pend_o)
    );

    // Reference model built from the requirements
    function automatic int pick_low(logic [7:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return 0;
    endfunction

    function automatic logic [7:0] vec_of(int i);
        return 8'(VBASE + (i + 1) * VSTEP);
    endfunction

    logic [1:0] m_st;
    logic [7:0] m_en, m_flags, m_vec, m_req, m_clr, m_take_oh;
    logic       m_gie, m_take;
    int         m_pick;

    always_comb begin
        m_req     = m_en & ((EDGE & m_flags) | (~EDGE & src_evt));
        m_take    = (m_st == 2'd0) && core_ready && m_gie && (m_req != 0);
        m_pick    = pick_low(m_req);
        m_take_oh = m_take ? 8'(1 << m_pick) : 8'h00;
        m_clr     = (wr_en && wr_addr == 2'd1) ? wr_data : 8'h00;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 2'd0; m_en <= '0; m_flags <= '0; m_gie <= 1'b0; m_vec <= 8'(VBASE);
        end else begin
            case (m_st)
                2'd0: if (m_take) m_st <= 2'd1;
                2'd1: m_st <= 2'd2;
                2'd2: if (!core_ready) m_st <= 2'd0;
                default: m_st <= 2'd0;
            endcase
            if (m_take) m_vec <= vec_of(m_pick);
            if (m_take) m_gie <= 1'b0;
            else if (wr_en && wr_addr == 2'd2) m_gie <= wr_data[0];
            else if (reti) m_gie <= 1'b1;
            if (wr_en && wr_addr == 2'd0) m_en <= wr_data;
            m_flags <= ((m_flags & ~m_clr & ~m_take_oh) | src_evt) & EDGE;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mdl_on) begin
            check("R1 R9 ack vs model", 32'(irq_ack), 32'(m_st == 2'd1));
            check("R7 R8 vector vs model", 32'(irq_vector), 32'(m_vec));
            check("R2 R10 gie vs model", 32'(gie_o), 32'(m_gie));
            check("R3 R4 R5 R11 flags vs model", 32'(pend_o), 32'(m_flags));
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            summary();
        end
    end

    task automatic idle();
        src_evt = lvl_hold; reti = 1'b0; wr_en = 1'b0; wr_addr = 2'd3; wr_data = '0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); idle(); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); idle();
    endtask

    task automatic pulse_evt(logic [7:0] m);
        @(negedge clk); idle(); src_evt = m | lvl_hold;
        @(negedge clk); idle();
    endtask

    task automatic do_reti();
        @(negedge clk); idle(); reti = 1'b1;
        @(negedge clk); idle();
    endtask

    task automatic serve(logic [7:0] exp_vec, string tag);
        logic seen = 1'b0;
        for (int k = 0; k < 5 && !seen; k++) begin
            @(negedge clk);
            if (irq_ack) begin
                seen = 1'b1;
                check(tag, 32'(irq_vector), 32'(exp_vec));
            end
        end
        check({tag, " ack seen"}, 32'(seen), 32'd1);
        core_ready = 1'b0;
        do_reti();
        core_ready = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd1234567));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mdl_on = 1'b1;
        // Reset state
        check("R8 reset vector", 32'(irq_vector), 32'(VBASE));
        check("R2 reset gie", 32'(gie_o), 32'd0);
        check("R9 reset ack", 32'(irq_ack), 32'd0);
        check("R11 reset flags", 32'(pend_o), 32'd0);

        // R6: level input gone before enabling gives nothing; held input is served
        wr(2'd2, 8'h01);
        check("R10 global write", 32'(gie_o), 32'd1);
        @(negedge clk); src_evt = 8'h20; core_ready = 1'b1;
        @(negedge clk); idle();
        wr(2'd0, 8'h20);
        for (int k = 0; k < 3; k++) begin
            check("R6 dropped level no ack", 32'(irq_ack), 32'd0);
            @(negedge clk);
        end
        src_evt = 8'h20;
        @(negedge clk);
        check("R6 level served", 32'(irq_ack), 32'd1);
        check("R8 level vector", 32'(irq_vector), 32'd12);
        check("R2 gie cleared on take", 32'(gie_o), 32'd0);
        idle(); core_ready = 1'b0;
        @(negedge clk);
        check("R9 ack single cycle", 32'(irq_ack), 32'd0);
        do_reti();
        check("R2 reti sets gie", 32'(gie_o), 32'd1);

        // R5 and R3: latched while disabled, fires once enabled, flag auto-cleared
        wr(2'd0, 8'h00);
        core_ready = 1'b1;
        pulse_evt(8'h04);
        check("R5 flag latched while disabled", 32'(pend_o), 32'h04);
        @(negedge clk);
        check("R5 no ack while disabled", 32'(irq_ack), 32'd0);
        wr(2'd0, 8'h04);
        @(negedge clk);
        check("R5 latched fires on enable", 32'(irq_ack), 32'd1);
        check("R8 vector source 2", 32'(irq_vector), 32'd6);
        check("R3 flag cleared on take", 32'(pend_o), 32'h00);
        core_ready = 1'b0;
        do_reti();

        // R4: write-one-to-clear
        wr(2'd0, 8'h00);
        pulse_evt(8'h02);
        wr(2'd1, 8'h00);
        check("R4 zero write keeps flag", 32'(pend_o), 32'h02);
        wr(2'd1, 8'hFD);
        check("R4 other ones keep flag", 32'(pend_o), 32'h02);
        wr(2'd1, 8'h02);
        check("R4 one clears flag", 32'(pend_o), 32'h00);
        wr(2'd3, 8'hFF);
        check("R10 address 3 no effect", 32'(gie_o), 32'd1);
        core_ready = 1'b1;
        wr(2'd0, 8'h02);
        for (int k = 0; k < 3; k++) begin
            check("R5 cleared flag never fires", 32'(irq_ack), 32'd0);
            @(negedge clk);
        end
        src_evt = 8'h02; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h02;
        @(negedge clk); idle();
        check("R4 event beats clear", 32'(pend_o), 32'h02);
        serve(8'd4, "R7 single latched");

        // R1 and R7: nothing while gie off, then lowest index first
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFF);
        lvl_hold = 8'h40;
        pulse_evt(8'h0A);
        for (int k = 0; k < 3; k++) begin
            check("R1 no take while gie off", 32'(irq_ack), 32'd0);
            @(negedge clk);
        end
        wr(2'd2, 8'h01);
        serve(8'd4, "R7 src1 first");
        serve(8'd8, "R7 src3 second");
        serve(8'd14, "R7 level src6 last");
        lvl_hold = 8'h00;
        idle();

        // Random phase checked against the model
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            src_evt    = 8'($urandom) & 8'($urandom) & 8'($urandom);
            core_ready = ($urandom % 4) != 0;
            reti       = ($urandom % 8) == 0;
            wr_en      = ($urandom % 6) == 0;
            wr_addr    = 2'($urandom);
            wr_data    = 8'($urandom);
        end
        @(negedge clk); idle();
        @(negedge clk);
        summary();
    end

endmodule